// File: doc/BRIEF.md
# Cache Way Replacement Selector

This block chooses which way of a set-associative cache is evicted when a line has to be refilled. The cache may have one to four ways. It keeps a small history per cache line and offers one of three replacement policies, chosen by a parameter. The random policy takes its choice from a free-running counter. The least-recently-replaced policy tracks only refills. The least-recently-used policy tracks every access.

The cache pipeline reports accesses (hits) and refills, each naming a line index and a way. To find a victim for a line, it presents that line index together with the line's per-way lock bits, which come from the tag store. The block then answers combinationally with a victim way and a valid flag. Locked ways are skipped in recency order. When every way of the line is locked, no victim is offered. Tag compare, data storage and the refill sequencing sit outside the block.

Top module: `way_victim_sel`

## Requirements
- R1: With NUM_WAYS = 1 the victim is always way 0. It is valid exactly when query_lock[0] is low.
- R2: Random policy (REPL_POLICY = 0). A counter is reset to 0 and advances by one on every clock edge out of reset, wrapping after NUM_WAYS-1. With 3 ways it therefore never produces the value 3. The victim is the counter value, or the first unlocked way after it, counting upward modulo NUM_WAYS.
- R3: LRU policy (REPL_POLICY = 2). The history of a line is updated by every access and every refill to that line. The victim is the unlocked way touched longest ago. When an access and a refill hit the same line in one cycle, the refill counts as the more recent event.
- R4: Least-recently-replaced policy (REPL_POLICY = 1, legal with 2 ways only). The history changes only on refills, and accesses leave the victim unchanged. The victim is the unlocked way that was not refilled most recently.
- R5: A line's history occupies 1 bit for 2 ways, 3 bits for 3 ways and 5 bits for 4 ways. It encodes a complete age ordering of the ways, and a stored code always names one of the NUM_WAYS! legal orderings. A code outside that range reads as the reset ordering.
- R6: After reset, every line holds the ordering in which way 0 is oldest and way NUM_WAYS-1 is newest. The history-based victim of every line is therefore way 0.
- R7: query_lock bit i locks way i (1 = locked) when LOCK_EN = 1. A locked way is never returned. In its place the next unlocked way in the policy's candidate order is returned, oldest first.
- R8: When all NUM_WAYS lock bits are set, victim_valid is 0 and victim_way is 0.
- R9: An access or refill that names a way index of NUM_WAYS or above changes no history.
- R10: An access to one line and a refill to a different line in the same cycle both update their own line, and no other line changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| touch_valid | input | 1 | An access (hit) occurred this cycle |
| touch_line | input | LINE_W | Line index of the access |
| touch_way | input | WAY_W | Way that was accessed (binary index) |
| fill_valid | input | 1 | A refill occurred this cycle |
| fill_line | input | LINE_W | Line index of the refill |
| fill_way | input | WAY_W | Way that was refilled (binary index) |
| query_line | input | LINE_W | Line whose victim is requested |
| query_lock | input | NUM_WAYS | Per-way lock bits of the queried line, bit i for way i |
| victim_way | output | WAY_W | Chosen victim way (binary index) |
| victim_valid | output | 1 | At least one unlocked way exists |

## Verification
Six small configurations are driven together by one pseudo-random stream of accesses and refills across four lines:
- 4-way and 3-way LRU
- 2-way least-recently-replaced
- 3-way and 4-way random
- 1-way

After every event, each line is queried under all sixteen lock patterns. The LRU instances are compared against a timestamp model. This separates the full 24- and 6-ordering encodings from a mere pseudo-LRU, and it shows whether a refill correctly outranks an access in the same cycle. The least-recently-replaced instance, fed the same accesses, shows whether accesses leak into its history. The random instances, compared against a cycle count modulo the way count, show whether the counter wraps correctly and whether the 3-way counter skips 3. Out-of-range way indices on the 3-way instance, and the all-locked patterns, exercise the ignore and no-victim cases.

// File: rtl/wvs_pkg.sv
package wvs_pkg;
  localparam int MAX_WAYS = 4;
  localparam int POL_RANDOM = 0;
  localparam int POL_LRR    = 1;
  localparam int POL_LRU    = 2;

  typedef logic [1:0] way_t;
  // Entry 0 is the oldest way, entry n-1 the newest.
  typedef way_t [MAX_WAYS-1:0] order_t;

  function automatic int fact(input int k);
    int r;
    r = 1;
    for (int i = 2; i <= MAX_WAYS; i++) if (i <= k) r = r * i;
    return r;
  endfunction

  function automatic int hist_bits(input int n);
    return (n == 4) ? 5 : (n == 3) ? 3 : 1;
  endfunction

  function automatic order_t base_order();
    order_t o;
    for (int i = 0; i < MAX_WAYS; i++) o[i] = way_t'(i);
    return o;
  endfunction

  // Permutation rank -> ordering; out-of-range ranks read as rank 0.
  function automatic order_t code_to_order(input logic [4:0] code, input int n);
    order_t o;
    way_t   avail [MAX_WAYS];
    int     rem, f, d;
    rem = int'(code);
    if (rem >= fact(n)) rem = 0;
    o = base_order();
    for (int i = 0; i < MAX_WAYS; i++) avail[i] = way_t'(i);
    for (int i = 0; i < MAX_WAYS; i++) begin
      if (i < n) begin
        f   = fact(n - 1 - i);
        d   = rem / f;
        rem = rem % f;
        for (int j = 0; j < MAX_WAYS; j++) if (j == d) o[i] = avail[j];
        for (int j = 0; j < MAX_WAYS - 1; j++) if (j >= d) avail[j] = avail[j+1];
      end
    end
    return o;
  endfunction

  function automatic logic [4:0] order_to_code(input order_t o, input int n);
    int c, d;
    c = 0;
    for (int i = 0; i < MAX_WAYS; i++) begin
      if (i < n) begin
        d = 0;
        for (int j = 0; j < MAX_WAYS; j++)
          if (j > i && j < n && o[j] < o[i]) d++;
        c = c + d * fact(n - 1 - i);
      end
    end
    return 5'(c);
  endfunction

  // Move way w to the newest slot; a way not in the ordering changes nothing.
  function automatic order_t promote(input order_t o, input way_t w, input int n);
    logic found;
    found = 1'b0;
    for (int i = 0; i < MAX_WAYS - 1; i++) begin
      if (i < n - 1) begin
        if (o[i] == w) found = 1'b1;
        if (found) o[i] = o[i+1];
      end
    end
    if (found)
      for (int i = 0; i < MAX_WAYS; i++) if (i == n - 1) o[i] = w;
    return o;
  endfunction

  function automatic order_t rotate_from(input way_t start, input int n);
    order_t o;
    o = base_order();
    for (int i = 0; i < MAX_WAYS; i++)
      if (i < n) o[i] = way_t'((int'(start) + i) % n);
    return o;
  endfunction
endpackage

// File: rtl/wvs_rand_gen.sv
module wvs_rand_gen #(
  parameter int NUM_WAYS = 4,
  parameter int RW       = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [RW-1:0] count
);
  logic [RW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                             cnt_q <= '0;
    else if (cnt_q == RW'(NUM_WAYS - 1))    cnt_q <= '0;
    else                                    cnt_q <= cnt_q + 1'b1;
  end

  assign count = cnt_q;
endmodule

// File: rtl/wvs_history.sv
module wvs_history
  import wvs_pkg::*;
#(
  parameter int NUM_WAYS  = 4,
  parameter int NUM_LINES = 8,
  parameter int HB        = 5,
  parameter int LINE_W    = 3,
  parameter bit UPD_TOUCH = 1'b1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    touch_valid,
  input  logic [LINE_W-1:0]       touch_line,
  input  way_t                    touch_way,
  input  logic                    fill_valid,
  input  logic [LINE_W-1:0]       fill_line,
  input  way_t                    fill_way,
  input  logic [LINE_W-1:0]       query_line,
  output logic [HB-1:0]           query_code,
  output logic [NUM_LINES*HB-1:0] hist_flat
);
  logic [HB-1:0] hist_q [NUM_LINES];
  logic [HB-1:0] hist_d [NUM_LINES];

  always_comb begin
    for (int l = 0; l < NUM_LINES; l++) begin
      order_t o;
      o = code_to_order(5'(hist_q[l]), NUM_WAYS);
      if (UPD_TOUCH && touch_valid && touch_line == LINE_W'(l))
        o = promote(o, touch_way, NUM_WAYS);
      if (fill_valid && fill_line == LINE_W'(l))
        o = promote(o, fill_way, NUM_WAYS);
      hist_d[l] = HB'(order_to_code(o, NUM_WAYS));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int l = 0; l < NUM_LINES; l++) hist_q[l] <= '0;
    end else begin
      for (int l = 0; l < NUM_LINES; l++) hist_q[l] <= hist_d[l];
    end
  end

  assign query_code = hist_q[query_line];

  for (genvar l = 0; l < NUM_LINES; l++) begin : g_flat
    assign hist_flat[l*HB +: HB] = hist_q[l];
  end
endmodule

// File: rtl/wvs_pick.sv
module wvs_pick
  import wvs_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int WAY_W    = 2
) (
  input  order_t              cand_order,
  input  logic [NUM_WAYS-1:0] lock_eff,
  output logic [WAY_W-1:0]    victim_way,
  output logic                victim_valid
);
  logic [MAX_WAYS-1:0] lk;

  always_comb begin
    lk = '0;
    lk[NUM_WAYS-1:0] = lock_eff;
    victim_way   = '0;
    victim_valid = 1'b0;
    // Scan newest to oldest so the oldest unlocked candidate wins.
    for (int i = MAX_WAYS - 1; i >= 0; i--) begin
      if (i < NUM_WAYS && !lk[cand_order[i]]) begin
        victim_way   = WAY_W'(cand_order[i]);
        victim_valid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/way_victim_sel.sv
module way_victim_sel
  import wvs_pkg::*;
#(
  parameter int NUM_WAYS    = 4,
  parameter int NUM_LINES   = 8,
  parameter int REPL_POLICY = POL_LRU,
  parameter bit LOCK_EN     = 1'b1,
  localparam int LINE_W     = (NUM_LINES > 1) ? $clog2(NUM_LINES) : 1,
  localparam int WAY_W      = (NUM_WAYS > 2) ? 2 : 1,
  localparam int HB         = hist_bits(NUM_WAYS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                touch_valid,
  input  logic [LINE_W-1:0]   touch_line,
  input  logic [WAY_W-1:0]    touch_way,
  input  logic                fill_valid,
  input  logic [LINE_W-1:0]   fill_line,
  input  logic [WAY_W-1:0]    fill_way,
  input  logic [LINE_W-1:0]   query_line,
  input  logic [NUM_WAYS-1:0] query_lock,
  output logic [WAY_W-1:0]    victim_way,
  output logic                victim_valid
);
  // Named internal events, observed by the bound checker.
  order_t                    cand_order;
  way_t                      cand_first;
  logic [NUM_WAYS-1:0]       lock_eff;
  logic [NUM_LINES*HB-1:0]   hist_flat;

  assign lock_eff   = LOCK_EN ? query_lock : '0;
  assign cand_first = cand_order[0];

  if (REPL_POLICY == POL_RANDOM) begin : g_random
    logic [WAY_W-1:0] rnd;
    wvs_rand_gen #(.NUM_WAYS(NUM_WAYS), .RW(WAY_W)) u_rand (
      .clk(clk), .rst_n(rst_n), .count(rnd)
    );
    assign cand_order = rotate_from(way_t'(rnd), NUM_WAYS);
    assign hist_flat  = '0;
  end else begin : g_history
    logic [HB-1:0] qcode;
    wvs_history #(
      .NUM_WAYS(NUM_WAYS), .NUM_LINES(NUM_LINES), .HB(HB), .LINE_W(LINE_W),
      .UPD_TOUCH(REPL_POLICY == POL_LRU)
    ) u_hist (
      .clk(clk), .rst_n(rst_n),
      .touch_valid(touch_valid), .touch_line(touch_line), .touch_way(way_t'(touch_way)),
      .fill_valid(fill_valid), .fill_line(fill_line), .fill_way(way_t'(fill_way)),
      .query_line(query_line), .query_code(qcode), .hist_flat(hist_flat)
    );
    assign cand_order = code_to_order(5'(qcode), NUM_WAYS);
  end

  wvs_pick #(.NUM_WAYS(NUM_WAYS), .WAY_W(WAY_W)) u_pick (
    .cand_order(cand_order), .lock_eff(lock_eff),
    .victim_way(victim_way), .victim_valid(victim_valid)
  );
endmodule

// File: rtl/wvs_checker.sv
module wvs_checker
  import wvs_pkg::*;
#(
  parameter int NUM_WAYS    = 4,
  parameter int NUM_LINES   = 8,
  parameter int REPL_POLICY = POL_LRU,
  parameter int HB          = 5,
  parameter int LINE_W      = 3,
  parameter int WAY_W       = 2
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    fill_valid,
  input logic [LINE_W-1:0]       fill_line,
  input logic [WAY_W-1:0]        fill_way,
  input logic [NUM_WAYS-1:0]     lock_eff,
  input logic [WAY_W-1:0]        victim_way,
  input logic                    victim_valid,
  input way_t                    cand_first,
  input logic [NUM_LINES*HB-1:0] hist_flat
);
  logic [MAX_WAYS-1:0] lk_pad;
  always_comb begin
    lk_pad = '0;
    lk_pad[NUM_WAYS-1:0] = lock_eff;
  end

  function automatic logic codes_legal(input logic [NUM_LINES*HB-1:0] h);
    logic ok;
    ok = 1'b1;
    for (int l = 0; l < NUM_LINES; l++)
      if (int'(h[l*HB +: HB]) >= fact(NUM_WAYS)) ok = 1'b0;
    return ok;
  endfunction

  function automatic way_t newest_of(input logic [NUM_LINES*HB-1:0] h,
                                     input logic [LINE_W-1:0] line);
    order_t o;
    way_t   w;
    o = base_order();
    w = '0;
    for (int l = 0; l < NUM_LINES; l++)
      if (line == LINE_W'(l)) o = code_to_order(5'(h[l*HB +: HB]), NUM_WAYS);
    for (int i = 0; i < MAX_WAYS; i++) if (i == NUM_WAYS - 1) w = o[i];
    return w;
  endfunction

  function automatic way_t rnd_next(input way_t w);
    return (int'(w) >= NUM_WAYS - 1) ? way_t'(0) : way_t'(w + 1'b1);
  endfunction

  AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    victim_valid |-> !lk_pad[way_t'(victim_way)]);  // R7

  AST_FREE_GIVES_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
    !(&lock_eff) |-> victim_valid);  // R7

  AST_ALL_LOCKED_NONE: assert property (@(posedge clk) disable iff (!rst_n)
    (&lock_eff) |-> (!victim_valid && victim_way == '0));  // R8

  AST_CAND_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(cand_first) < NUM_WAYS);  // R2

  if (REPL_POLICY == POL_RANDOM) begin : g_rnd_chk
    AST_RND_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> cand_first == rnd_next($past(cand_first)));  // R2
  end else begin : g_hist_chk
    AST_CODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      codes_legal(hist_flat));  // R5

    AST_FILL_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_valid && int'(fill_way) < NUM_WAYS)
      |=> newest_of(hist_flat, $past(fill_line)) == way_t'($past(fill_way)));  // R3

    if (REPL_POLICY == POL_LRR) begin : g_lrr_chk
      AST_LRR_NO_TOUCH: assert property (@(posedge clk) disable iff (!rst_n)
        !fill_valid |=> $stable(hist_flat));  // R4
    end
  end
endmodule

bind way_victim_sel wvs_checker #(
  .NUM_WAYS(NUM_WAYS), .NUM_LINES(NUM_LINES), .REPL_POLICY(REPL_POLICY),
  .HB(HB), .LINE_W(LINE_W), .WAY_W(WAY_W)
) u_wvs_checker (
  .clk(clk), .rst_n(rst_n), .fill_valid(fill_valid), .fill_line(fill_line),
  .fill_way(fill_way), .lock_eff(lock_eff), .victim_way(victim_way),
  .victim_valid(victim_valid), .cand_first(cand_first), .hist_flat(hist_flat)
);

// File: tb/test_way_victim_sel.sv
module test_way_victim_sel;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;
  localparam int STEPS      = 60;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       tv = 1'b0, fv = 1'b0;
  logic [1:0] tl = '0, tw = '0, fl = '0, fw = '0, ql = '0;
  logic [3:0] qlk = '0;

  logic [1:0] vw_a, vw_l3, vw_r3, vw_r4;
  logic       vw_lr, vw_one;
  logic       vv_a, vv_l3, vv_lr, vv_r3, vv_r4, vv_one;

  way_victim_sel #(.NUM_WAYS(4), .NUM_LINES(4), .REPL_POLICY(2)) i_way_victim_sel (
    .clk(clk), .rst_n(rst_n), .touch_valid(tv), .touch_line(tl), .touch_way(tw),
    .fill_valid(fv), .fill_line(fl), .fill_way(fw), .query_line(ql),
    .query_lock(qlk), .victim_way(vw_a), .victim_valid(vv_a));
  way_victim_sel #(.NUM_WAYS(3), .NUM_LINES(4), .REPL_POLICY(2)) i_lru3 (
    .clk(clk), .rst_n(rst_n), .touch_valid(tv), .touch_line(tl), .touch_way(tw),
    .fill_valid(fv), .fill_line(fl), .fill_way(fw), .query_line(ql),
    .query_lock(qlk[2:0]), .victim_way(vw_l3), .victim_valid(vv_l3));
  way_victim_sel #(.NUM_WAYS(2), .NUM_LINES(4), .REPL_POLICY(1)) i_lrr2 (
    .clk(clk), .rst_n(rst_n), .touch_valid(tv), .touch_line(tl), .touch_way(tw[0:0]),
    .fill_valid(fv), .fill_line(fl), .fill_way(fw[0:0]), .query_line(ql),
    .query_lock(qlk[1:0]), .victim_way(vw_lr), .victim_valid(vv_lr));
  way_victim_sel #(.NUM_WAYS(3), .NUM_LINES(4), .REPL_POLICY(0)) i_rnd3 (
    .clk(clk), .rst_n(rst_n), .touch_valid(tv), .touch_line(tl), .touch_way(tw),
    .fill_valid(fv), .fill_line(fl), .fill_way(fw), .query_line(ql),
    .query_lock(qlk[2:0]), .victim_way(vw_r3), .victim_valid(vv_r3));
  way_victim_sel #(.NUM_WAYS(4), .NUM_LINES(4), .REPL_POLICY(0)) i_rnd4 (
    .clk(clk), .rst_n(rst_n), .touch_valid(tv), .touch_line(tl), .touch_way(tw),
    .fill_valid(fv), .fill_line(fl), .fill_way(fw), .query_line(ql),
    .query_lock(qlk), .victim_way(vw_r4), .victim_valid(vv_r4));
  way_victim_sel #(.NUM_WAYS(1), .NUM_LINES(4), .REPL_POLICY(2)) i_one (
    .clk(clk), .rst_n(rst_n), .touch_valid(tv), .touch_line(tl), .touch_way(tw[0:0]),
    .fill_valid(fv), .fill_line(fl), .fill_way(fw[0:0]), .query_line(ql),
    .query_lock(qlk[0:0]), .victim_way(vw_one), .victim_valid(vv_one));

  int checks = 0, fails = 0;
  int cyc = 0;          // clock edges taken out of reset
  int tnow = 10;
  int st4 [4][4], st3 [4][4], st2 [4][4];
  logic [15:0] lfsr = 16'hACE1;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // Timestamp model: the oldest unlocked way has the smallest stamp.
  function automatic int oldest(input int row [4], input int n, input logic [3:0] lk);
    int best;
    best = -1;
    for (int w = 0; w < n; w++)
      if (!lk[w] && (best < 0 || row[w] < row[best])) best = w;
    return best;
  endfunction

  function automatic int rnd_pick(input int r, input int n, input logic [3:0] lk);
    for (int i = 0; i < n; i++)
      if (!lk[(r + i) % n]) return (r + i) % n;
    return -1;
  endfunction

  task automatic chk(input string tag, input logic gv, input logic [1:0] gw, input int exp);
    logic       ev;
    logic [1:0] ew;
    ev = (exp >= 0);
    ew = ev ? 2'(exp) : 2'd0;
    checks++;
    if (gv !== ev || gw !== ew) begin
      fails++;
      $display("FAIL %s%s line=%0d lock=%b: got valid=%b way=%0d, expected valid=%b way=%0d",
               ev ? "" : "R8 ", tag, ql, qlk, gv, gw, ev, ew);
    end
  endtask

  task automatic check_all(input string phase);
    for (int l = 0; l < 4; l++) begin
      for (int m = 0; m < 16; m++) begin
        @(negedge clk);
        ql  = 2'(l);
        qlk = 4'(m);
        #1;
        chk({phase, "R3/R5/R7 LRU 4-way"}, vv_a, vw_a, oldest(st4[l], 4, qlk));
        chk({phase, "R9 LRU 3-way"}, vv_l3, vw_l3, oldest(st3[l], 3, qlk));
        chk({phase, "R4 LRR 2-way"}, vv_lr, {1'b0, vw_lr}, oldest(st2[l], 2, qlk));
        chk({phase, "R2 RND 3-way"}, vv_r3, vw_r3, rnd_pick(cyc % 3, 3, qlk));
        chk({phase, "R2 RND 4-way"}, vv_r4, vw_r4, rnd_pick(cyc % 4, 4, qlk));
        chk({phase, "R1 one-way"}, vv_one, {1'b0, vw_one}, qlk[0] ? -1 : 0);
      end
    end
  endtask

  // R10: access and refill lines are drawn independently each step.
  task automatic step();
    for (int k = 0; k < 11; k++) lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    @(negedge clk);
    tv = lfsr[0]; tl = lfsr[2:1]; tw = lfsr[4:3];
    fv = lfsr[5]; fl = lfsr[7:6]; fw = lfsr[9:8];
    @(posedge clk);
    #1;
    if (tv) begin
      st4[tl][tw] = tnow;
      if (tw < 3) st3[tl][tw] = tnow;   // R9: way 3 absent in 3-way
    end
    if (fv) begin
      st4[fl][fw] = tnow + 1;           // R3: refill newer than same-cycle access
      if (fw < 3) st3[fl][fw] = tnow + 1;
      st2[fl][fw[0]] = tnow + 1;        // R4: only refills move LRR history
    end
    tnow += 2;
    @(negedge clk);
    tv = 1'b0;
    fv = 1'b0;
  endtask

  initial begin
    for (int l = 0; l < 4; l++)
      for (int w = 0; w < 4; w++) begin
        st4[l][w] = w; st3[l][w] = w; st2[l][w] = w;
      end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check_all("R6 reset ");
    for (int s = 0; s < STEPS; s++) begin
      step();
      check_all("");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired after %0d cycles, expected completion", WATCHDOG);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule